// File: doc/BRIEF.md
# Blank-Interval Commit Latch

This block runs the raster position counters of a display timing path and marks three instants inside vertical blanking: a startup event, an update event and a ready event. Each event sits at its own programmed line and pixel and has no tie to where the vsync pulse is placed. It also holds a bank of configuration words, such as a surface base address. Each word has a pending (shadow) copy and a live (active) copy.

Software may write the shadow copies at any time. The active copies move only at the update event, and all words move on the same clock edge. A frame may see several writes to one word before the update event; only the last of them goes live. A hold input can stall the transfer so that software can stage a change across several words. A pending flag shows that shadow data has not yet been committed. A one-cycle done pulse follows every real transfer. Position programming that puts an event outside blanking, or that places two events on the same spot, raises an error flag, and no events are produced while the flag is high.

Top module: `blank_commit_latch`

## Requirements
- R1: After reset the raster position is line 0, pixel 0. The pixel count runs to H_TOTAL-1 and then wraps to 0 while the line count steps by one. The line count wraps from V_TOTAL-1 to 0.
- R2: When programming is valid, each frame has exactly one startup, one update and one ready pulse. Each pulse lasts one cycle, in the cycle where the position equals that event's programmed line and pixel.
- R3: No pulse occurs on a line below V_ACTIVE, and no two pulses are high in the same cycle.
- R4: vsync_o is high exactly on lines VS_FIRST through VS_LAST. Its placement does not depend on the event positions.
- R5: prog_err is high when any event line is below V_ACTIVE or at or above V_TOTAL, when any event pixel is at or above H_TOTAL, or when two events share a line and pixel. While prog_err is high, all three pulses stay low.
- R6: A shadow write does not change any active output before the next update pulse.
- R7: In an update cycle with hold_commit low, every active word takes its shadow value at the clock edge that ends that cycle, all in the same edge. Word i appears at active_flat[i*REG_W +: REG_W].
- R8: Among several writes to one word before an update pulse, only the last goes live. A write captured at the edge that ends the update cycle is not transferred by that update; it goes live at the next update pulse.
- R9: While hold_commit is high, the update pulse transfers nothing and the shadow data is kept. The first update pulse after hold_commit drops commits all words staged during the hold.
- R10: commit_done is high for exactly the one cycle after an update cycle that transferred. It stays low after an update cycle that was held.
- R11: pending is set by any shadow write and cleared by a transfer. A write in the transfer cycle itself leaves pending set.
- R12: While reset is asserted, every active word equals RST_VAL, pending and commit_done are low, and the position is line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Shadow write strobe |
| cfg_wr_addr | input | $clog2(N_REGS) | Shadow word index |
| cfg_wr_data | input | REG_W | Shadow write data |
| hold_commit | input | 1 | Stalls the shadow-to-active transfer while high |
| start_line | input | $clog2(V_TOTAL+1) | Startup event line |
| start_pixel | input | $clog2(H_TOTAL+1) | Startup event pixel |
| update_line | input | $clog2(V_TOTAL+1) | Update event line |
| update_pixel | input | $clog2(H_TOTAL+1) | Update event pixel |
| ready_line | input | $clog2(V_TOTAL+1) | Ready event line |
| ready_pixel | input | $clog2(H_TOTAL+1) | Ready event pixel |
| pos_line | output | $clog2(V_TOTAL+1) | Current raster line |
| pos_pixel | output | $clog2(H_TOTAL+1) | Current raster pixel |
| vsync_o | output | 1 | Vertical sync level |
| ev_start | output | 1 | Startup event pulse |
| ev_update | output | 1 | Update event pulse |
| ev_ready | output | 1 | Ready event pulse |
| commit_done | output | 1 | One-cycle pulse after a transfer |
| pending | output | 1 | Shadow data not yet committed |
| prog_err | output | 1 | Event position programming is invalid |
| active_flat | output | N_REGS*REG_W | All active words, packed |

## Verification
The bench builds the block with a 10-pixel by 8-line raster, 5 active lines, vsync on lines 5 and 6, and four 16-bit words. A frame is therefore 80 cycles, so whole frames can be scanned pulse by pulse, and both counter wraps come up within a few hundred cycles. The small geometry also makes it cheap to move an event outside blanking, past the line end, or onto another event. The same settings let several commit rounds with and without hold, plus a write landing exactly on the update edge, fit into a short run.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  localparam int NUM_EV = 3;
  typedef enum logic [1:0] {
    EV_START  = 2'd0,
    EV_UPDATE = 2'd1,
    EV_READY  = 2'd2
  } ev_e;
endpackage

// File: rtl/bcl_raster.sv
module bcl_raster #(
  parameter int H_TOTAL  = 2200,
  parameter int V_TOTAL  = 1125,
  parameter int VS_FIRST = 1084,
  parameter int VS_LAST  = 1088,
  parameter int PW       = $clog2(H_TOTAL + 1),
  parameter int LW       = $clog2(V_TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pixel_q,
  output logic [LW-1:0] line_q,
  output logic          vsync
);
  localparam logic [PW-1:0] H_LAST = PW'(H_TOTAL - 1);
  localparam logic [LW-1:0] V_LAST = LW'(V_TOTAL - 1);
  localparam logic [LW-1:0] VS_A   = LW'(VS_FIRST);
  localparam logic [LW-1:0] VS_B   = LW'(VS_LAST);

  logic          px_end;
  logic [PW-1:0] pixel_d;
  logic [LW-1:0] line_d;
  logic          line_en;

  always_comb begin
    px_end  = (pixel_q == H_LAST);
    line_en = px_end;
    pixel_d = px_end ? '0 : pixel_q + 1'b1;
    line_d  = (line_q == V_LAST) ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixel_q <= '0;
    end else begin
      pixel_q <= pixel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (line_en) begin
      line_q <= line_d;
    end
  end

  assign vsync = (line_q >= VS_A) && (line_q <= VS_B);

  a_r1_pixel_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pixel_q == H_LAST) |=> (pixel_q == '0));
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pixel_q == H_LAST && line_q == V_LAST) |=> (line_q == '0));
endmodule

// File: rtl/bcl_event_gen.sv
module bcl_event_gen
  import bcl_pkg::*;
#(
  parameter int H_TOTAL  = 2200,
  parameter int V_TOTAL  = 1125,
  parameter int V_ACTIVE = 1080,
  parameter int PW       = $clog2(H_TOTAL + 1),
  parameter int LW       = $clog2(V_TOTAL + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PW-1:0]                pixel,
  input  logic [LW-1:0]                line,
  input  logic [NUM_EV-1:0][LW-1:0]    ev_line,
  input  logic [NUM_EV-1:0][PW-1:0]    ev_pixel,
  output logic [NUM_EV-1:0]            pulse,
  output logic                         err
);
  localparam logic [LW-1:0] VA_L = LW'(V_ACTIVE);
  localparam logic [LW-1:0] VT_L = LW'(V_TOTAL);
  localparam logic [PW-1:0] HT_L = PW'(H_TOTAL);

  logic [NUM_EV-1:0] in_range;
  logic [NUM_EV-1:0] hit;
  logic              collide;

  for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
    assign in_range[k] = (ev_line[k] >= VA_L) && (ev_line[k] < VT_L) &&
                         (ev_pixel[k] < HT_L);
    assign hit[k]      = (line == ev_line[k]) && (pixel == ev_pixel[k]);
    assign pulse[k]    = hit[k] & ~err;
  end

  always_comb begin
    collide = 1'b0;
    for (int a = 0; a < NUM_EV; a++) begin
      for (int b = a + 1; b < NUM_EV; b++) begin
        if (ev_line[a] == ev_line[b] && ev_pixel[a] == ev_pixel[b]) begin
          collide = 1'b1;
        end
      end
    end
  end

  assign err = collide | ~(&in_range);

  a_r3_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pulse) <= 1);
  a_r3_inside_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |-> (line >= VA_L));
  a_r5_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pulse == '0));
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse[EV_UPDATE] |=> !pulse[EV_UPDATE]);
endmodule

// File: rtl/bcl_shadow_bank.sv
module bcl_shadow_bank #(
  parameter int              N_REGS  = 4,
  parameter int              REG_W   = 32,
  parameter int              AW      = $clog2(N_REGS),
  parameter logic [REG_W-1:0] RST_VAL = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic                    commit_ev,
  input  logic                    hold,
  output logic [N_REGS*REG_W-1:0] active_flat,
  output logic                    pending_q,
  output logic                    done_q
);
  logic [N_REGS-1:0][REG_W-1:0] shadow_q;
  logic [N_REGS-1:0][REG_W-1:0] active_q;
  logic [N_REGS-1:0]            sh_en;
  logic                         take;
  logic                         pending_d;

  assign take = commit_ev & ~hold;

  for (genvar i = 0; i < N_REGS; i++) begin : g_word
    assign sh_en[i] = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[i] <= RST_VAL;
      end else if (sh_en[i]) begin
        shadow_q[i] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q[i] <= RST_VAL;
      end else if (take) begin
        active_q[i] <= shadow_q[i];
      end
    end

    assign active_flat[i*REG_W +: REG_W] = active_q[i];
  end

  always_comb begin
    pending_d = pending_q;
    if (take)  pending_d = 1'b0;
    if (wr_en) pending_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      pending_q <= pending_d;
      done_q    <= take;
    end
  end

  a_r6_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_ev && !hold) |=> $stable(active_flat));
  a_r10_done_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(commit_ev && !hold));
  a_r9_hold_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && hold) |=> !done_q);
  a_r11_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pending_q);
endmodule

// File: rtl/blank_commit_latch.sv
module blank_commit_latch
  import bcl_pkg::*;
#(
  parameter int               H_TOTAL  = 2200,
  parameter int               V_TOTAL  = 1125,
  parameter int               V_ACTIVE = 1080,
  parameter int               VS_FIRST = 1084,
  parameter int               VS_LAST  = 1088,
  parameter int               N_REGS   = 4,
  parameter int               REG_W    = 32,
  parameter logic [REG_W-1:0] RST_VAL  = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_wr_en,
  input  logic [$clog2(N_REGS)-1:0]       cfg_wr_addr,
  input  logic [REG_W-1:0]                cfg_wr_data,
  input  logic                            hold_commit,
  input  logic [$clog2(V_TOTAL+1)-1:0]    start_line,
  input  logic [$clog2(H_TOTAL+1)-1:0]    start_pixel,
  input  logic [$clog2(V_TOTAL+1)-1:0]    update_line,
  input  logic [$clog2(H_TOTAL+1)-1:0]    update_pixel,
  input  logic [$clog2(V_TOTAL+1)-1:0]    ready_line,
  input  logic [$clog2(H_TOTAL+1)-1:0]    ready_pixel,
  output logic [$clog2(V_TOTAL+1)-1:0]    pos_line,
  output logic [$clog2(H_TOTAL+1)-1:0]    pos_pixel,
  output logic                            vsync_o,
  output logic                            ev_start,
  output logic                            ev_update,
  output logic                            ev_ready,
  output logic                            commit_done,
  output logic                            pending,
  output logic                            prog_err,
  output logic [N_REGS*REG_W-1:0]         active_flat
);
  localparam int PW = $clog2(H_TOTAL + 1);
  localparam int LW = $clog2(V_TOTAL + 1);
  localparam int AW = $clog2(N_REGS);

  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [NUM_EV-1:0][LW-1:0]    ev_line;
  logic [NUM_EV-1:0][PW-1:0]    ev_pixel;
  logic [NUM_EV-1:0]            pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign ev_line[EV_START]   = start_line;
  assign ev_pixel[EV_START]  = start_pixel;
  assign ev_line[EV_UPDATE]  = update_line;
  assign ev_pixel[EV_UPDATE] = update_pixel;
  assign ev_line[EV_READY]   = ready_line;
  assign ev_pixel[EV_READY]  = ready_pixel;

  bcl_raster #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .VS_FIRST(VS_FIRST),
    .VS_LAST(VS_LAST), .PW(PW), .LW(LW)
  ) u_raster (
    .clk(clk), .rst_n(rst_int_n), .pixel_q(pos_pixel), .line_q(pos_line),
    .vsync(vsync_o)
  );

  bcl_event_gen #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .V_ACTIVE(V_ACTIVE),
    .PW(PW), .LW(LW)
  ) u_events (
    .clk(clk), .rst_n(rst_int_n), .pixel(pos_pixel), .line(pos_line),
    .ev_line(ev_line), .ev_pixel(ev_pixel), .pulse(pulse), .err(prog_err)
  );

  assign ev_start  = pulse[EV_START];
  assign ev_update = pulse[EV_UPDATE];
  assign ev_ready  = pulse[EV_READY];

  bcl_shadow_bank #(
    .N_REGS(N_REGS), .REG_W(REG_W), .AW(AW), .RST_VAL(RST_VAL)
  ) u_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .commit_ev(ev_update), .hold(hold_commit),
    .active_flat(active_flat), .pending_q(pending), .done_q(commit_done)
  );

  a_r7_commit_reports: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_update && !hold_commit) |=> commit_done);
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    commit_done |=> !commit_done);
endmodule

// File: tb/sim_blank_commit_latch.sv
module sim_blank_commit_latch;
  localparam int HT = 10;
  localparam int VT = 8;
  localparam int VA = 5;
  localparam int NR = 4;
  localparam int RW = 16;
  localparam logic [RW-1:0] RV = 16'hA5A5;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en;
  logic [1:0] cfg_wr_addr;
  logic [RW-1:0] cfg_wr_data;
  logic hold_commit;
  logic [3:0] start_line, update_line, ready_line;
  logic [3:0] start_pixel, update_pixel, ready_pixel;
  logic [3:0] pos_line, pos_pixel;
  logic vsync_o, ev_start, ev_update, ev_ready, commit_done, pending, prog_err;
  logic [NR*RW-1:0] active_flat;

  int checks = 0;
  int fails = 0;
  logic [RW-1:0] m_shadow [NR];
  logic [RW-1:0] m_active [NR];

  // {hold, addr, data}
  localparam logic [18:0] TBL [6] = '{
    {1'b0, 2'd0, 16'h1111}, {1'b0, 2'd3, 16'h2222}, {1'b1, 2'd1, 16'h3333},
    {1'b1, 2'd2, 16'h4444}, {1'b0, 2'd1, 16'h5555}, {1'b0, 2'd0, 16'h6666}};

  always #10 clk = ~clk;

  blank_commit_latch #(
    .H_TOTAL(HT), .V_TOTAL(VT), .V_ACTIVE(VA), .VS_FIRST(5), .VS_LAST(6),
    .N_REGS(NR), .REG_W(RW), .RST_VAL(RV)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .hold_commit(hold_commit),
    .start_line(start_line), .start_pixel(start_pixel),
    .update_line(update_line), .update_pixel(update_pixel),
    .ready_line(ready_line), .ready_pixel(ready_pixel),
    .pos_line(pos_line), .pos_pixel(pos_pixel), .vsync_o(vsync_o),
    .ev_start(ev_start), .ev_update(ev_update), .ev_ready(ev_ready),
    .commit_done(commit_done), .pending(pending), .prog_err(prog_err),
    .active_flat(active_flat)
  );

  function automatic logic [RW-1:0] act(int i);
    return active_flat[i*RW +: RW];
  endfunction

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic wait_pos(input int l, input int p);
    int n = 0;
    while (!(pos_line == 4'(l) && pos_pixel == 4'(p)) && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n < 400, "R1 position reached", n, 0);
  endtask

  task automatic wr(input int a, input logic [RW-1:0] d);
    cfg_wr_en = 1'b1;
    cfg_wr_addr = 2'(a);
    cfg_wr_data = d;
    m_shadow[a] = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NR; i++) chk(act(i) == m_active[i], tag, act(i), m_active[i]);
  endtask

  task automatic scan_frame(input bit expect_pulses, input int ul, input int up);
    int ns = 0, nu = 0, nr = 0, multi = 0, outside = 0, vsbad = 0, uat = 0;
    wait_pos(0, 0);
    for (int c = 0; c < HT * VT; c++) begin
      ns += ev_start; nu += ev_update; nr += ev_ready;
      if (32'(ev_start) + 32'(ev_update) + 32'(ev_ready) > 1) multi++;
      if ((ev_start | ev_update | ev_ready) && pos_line < 4'(VA)) outside++;
      if (vsync_o != (pos_line == 4'd5 || pos_line == 4'd6)) vsbad++;
      if (ev_update && pos_line == 4'(ul) && pos_pixel == 4'(up)) uat++;
      @(negedge clk);
    end
    if (expect_pulses) begin
      chk(ns == 1, "R2 start count", ns, 1);
      chk(nu == 1, "R2 update count", nu, 1);
      chk(nr == 1, "R2 ready count", nr, 1);
      chk(uat == 1, "R2 update at programmed spot", uat, 1);
    end else begin
      chk(ns + nu + nr == 0, "R5 no pulses under error", ns + nu + nr, 0);
    end
    chk(multi == 0, "R3 pulses exclusive", multi, 0);
    chk(outside == 0, "R3 pulses in blanking", outside, 0);
    chk(vsbad == 0, "R4 vsync lines", vsbad, 0);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0; hold_commit = 1'b0;
    start_line = 4'd5; start_pixel = 4'd2;
    update_line = 4'd6; update_pixel = 4'd3;
    ready_line = 4'd7; ready_pixel = 4'd1;
    for (int i = 0; i < NR; i++) begin m_shadow[i] = RV; m_active[i] = RV; end
    repeat (3) @(negedge clk);
    // R12 reset state
    check_all("R12 reset active");
    chk(pending == 1'b0, "R12 reset pending", pending, 0);
    chk(commit_done == 1'b0, "R12 reset done", commit_done, 0);
    chk(pos_line == 0 && pos_pixel == 0, "R12 reset position", {pos_line, pos_pixel}, 0);
    rst_n = 1'b1;

    // R1 wraps
    wait_pos(0, 9); @(negedge clk);
    chk(pos_line == 1 && pos_pixel == 0, "R1 pixel wrap", {pos_line, pos_pixel}, 8'h10);
    wait_pos(7, 9); @(negedge clk);
    chk(pos_line == 0 && pos_pixel == 0, "R1 line wrap", {pos_line, pos_pixel}, 0);
    chk(prog_err == 1'b0, "R5 valid programming", prog_err, 0);

    scan_frame(1'b1, 6, 3);

    // table of commit rounds: R6 R7 R9 R10 R11
    for (int e = 0; e < 6; e++) begin
      hold_commit = TBL[e][18];
      wait_pos(1, 0);
      wr(int'(TBL[e][17:16]), TBL[e][15:0]);
      check_all("R6 active unchanged after write");
      chk(pending == 1'b1, "R11 pending after write", pending, 1);
      wait_pos(6, 3);
      chk(ev_update == 1'b1, "R2 update pulse", ev_update, 1);
      @(negedge clk);
      if (!TBL[e][18]) for (int i = 0; i < NR; i++) m_active[i] = m_shadow[i];
      check_all(TBL[e][18] ? "R9 held commit" : "R7 commit");
      chk(commit_done == !TBL[e][18], "R10 done pulse", commit_done, !TBL[e][18]);
      chk(pending == TBL[e][18], "R11 pending after update", pending, TBL[e][18]);
    end
    hold_commit = 1'b0;
    @(negedge clk);
    chk(commit_done == 1'b0, "R10 done single cycle", commit_done, 0);

    // R8 mailbox
    wait_pos(2, 0);
    wr(2, 16'hAAAA); wr(2, 16'hBBBB); wr(2, 16'hCCCC);
    check_all("R6 active unchanged after burst");
    wait_pos(6, 3); @(negedge clk);
    for (int i = 0; i < NR; i++) m_active[i] = m_shadow[i];
    chk(act(2) == 16'hCCCC, "R8 last write wins", act(2), 16'hCCCC);

    // R8 / R11 write on the update edge
    wait_pos(6, 3);
    wr(1, 16'h7777);
    chk(act(1) == 16'h5555, "R8 same-edge write not taken", act(1), 16'h5555);
    chk(pending == 1'b1, "R11 same-edge write keeps pending", pending, 1);
    chk(commit_done == 1'b1, "R10 done on same-edge round", commit_done, 1);
    wait_pos(6, 3); @(negedge clk);
    chk(act(1) == 16'h7777, "R8 same-edge write taken next", act(1), 16'h7777);
    chk(pending == 1'b0, "R11 pending cleared", pending, 0);

    // R2 moved update position
    update_line = 4'd7; update_pixel = 4'd5;
    scan_frame(1'b1, 7, 5);

    // R5 error cases
    update_line = 4'd5; update_pixel = 4'd2;
    #1 chk(prog_err == 1'b1, "R5 collision flag", prog_err, 1);
    scan_frame(1'b0, 0, 0);
    update_line = 4'd6; update_pixel = 4'd3;
    start_line = 4'd2;
    #1 chk(prog_err == 1'b1, "R5 line in active area", prog_err, 1);
    start_line = 4'd8;
    #1 chk(prog_err == 1'b1, "R5 line past total", prog_err, 1);
    start_line = 4'd5; ready_pixel = 4'd10;
    #1 chk(prog_err == 1'b1, "R5 pixel past total", prog_err, 1);
    ready_pixel = 4'd1;
    #1 chk(prog_err == 1'b0, "R5 error cleared", prog_err, 0);

    // R12 reset mid-run
    @(negedge clk);
    wr(0, 16'h1234);
    rst_n = 1'b0;
    for (int i = 0; i < NR; i++) begin m_shadow[i] = RV; m_active[i] = RV; end
    @(negedge clk);
    check_all("R12 reset restores active");
    chk(pending == 1'b0, "R12 reset clears pending", pending, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule